// File: doc/BRIEF.md
# Floating-Point Control Register Bank

This block holds the control and status state that a floating-point unit keeps next to its datapath. That state covers the x87 status, tag, control and last-opcode words, the SIMD control/status word, the stack-top pointer, and the segment selectors and offsets of the last instruction and operand. Software and microcode write any of these through a single indexed write port. The bank cuts each value down to the width the register has in the architecture. For the selector and offset pointers, that width depends on the `longMode` input sampled in the cycle of the write.

The stack-top pointer is a separate 3-bit register. A write to the status word also loads it from the written value. A read of the status word rebuilds the full word by placing the current stack-top value into bits 13:11. The read port is combinational. It shows the state as it was after the last clock edge.

Register indices: 0 status word, 1 stack top, 2 tag word, 3 control word, 4 last opcode, 5 SIMD control/status, 6 instruction selector, 7 operand selector, 8 instruction offset, 9 operand offset.

Top module: `fpcr_bank`

## Requirements
- R1: After reset, a read of every index 0 to 15 returns zero.
- R2: A write to index 0 stores bits 15:0 of the data, apart from bits 13:11. A read of index 0 returns that stored word with bits 13:11 taken from the stack-top register and bits 63:16 zero.
- R3: A write to index 0 also loads the stack-top register (index 1) with bits 13:11 of the written data.
- R4: A write to index 1 keeps bits 2:0 only. The new value shows on reads of index 1 and in bits 13:11 of the next read of index 0.
- R5: A write to index 2 keeps bits 7:0. All higher bits read as zero.
- R6: A write to index 3 or index 4 keeps bits 15:0.
- R7: A write to index 5 keeps bits 31:0.
- R8: A write to index 6 or 7 keeps bits 15:0 when `longMode` is 0. It keeps all 64 bits when `longMode` is 1. A later change of `longMode` does not alter the stored value.
- R9: A write to index 8 or 9 keeps bits 31:0 when `longMode` is 0. It keeps all 64 bits when `longMode` is 1.
- R10: A cycle with `wrEn` low, or a write to an index from 10 to 15, changes no register. A read of an index from 10 to 15 returns zero.
- R11: A write becomes visible on the read port only after the rising clock edge that takes it. Before that edge the read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrIdx | input | 4 | Register index of the write |
| wrData | input | 64 | Write value before truncation |
| longMode | input | 1 | High while the processor is in 64-bit submode |
| rdIdx | input | 4 | Register index of the read |
| rdData | output | 64 | Read value of the register at `rdIdx` |

## Verification
On every cycle, the bound checker confirms that each fixed-width register reads back with zero upper bits and that unmapped indices read zero. It also confirms, one cycle after a write, that a status write has moved its bits 13:11 into the stack-top register and that selector and offset writes were cut according to the mode at the time of the write. Some behaviour can only be shown by the bench's scenarios. These include splicing a later stack-top write into the status word, keeping a wide value after the mode drops, leaving every register untouched under disabled or unmapped writes, and the old value holding until the write edge.

// File: rtl/fpcr_pkg.sv
package fpcr_pkg;
  localparam int IDX_W    = 4;
  localparam int NUM_REGS = 10;

  localparam int IDX_STATUS = 0;
  localparam int IDX_TOP    = 1;
  localparam int IDX_TAG    = 2;
  localparam int IDX_CTRL   = 3;
  localparam int IDX_OPC    = 4;
  localparam int IDX_SIMD   = 5;
  localparam int IDX_ISEL   = 6;
  localparam int IDX_OSEL   = 7;
  localparam int IDX_IOFF   = 8;
  localparam int IDX_OOFF   = 9;

  localparam int TOP_LO = 11;
  localparam int TOP_W  = 3;

  localparam int WORD_BITS = 16;
  localparam int TAG_BITS  = 8;
  localparam int SIMD_BITS = 32;
  localparam int SEL_BITS  = 16;
  localparam int OFF_BITS  = 32;

  typedef struct packed {
    logic [NUM_REGS-1:0] load;
    logic                topFromStatus;
    logic                wide;
  } fpcrStrobe_t;

  function automatic int fieldBits(int idx, bit wide, int dataW);
    case (idx)
      IDX_STATUS, IDX_CTRL, IDX_OPC: return WORD_BITS;
      IDX_TOP:                       return TOP_W;
      IDX_TAG:                       return TAG_BITS;
      IDX_SIMD:                      return SIMD_BITS;
      IDX_ISEL, IDX_OSEL:            return wide ? dataW : SEL_BITS;
      IDX_IOFF, IDX_OOFF:            return wide ? dataW : OFF_BITS;
      default:                       return 0;
    endcase
  endfunction
endpackage

// File: rtl/fpcr_ctrl.sv
module fpcr_ctrl
  import fpcr_pkg::*;
(
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             longMode,
  output fpcrStrobe_t      strobe
);
  always_comb begin
    strobe      = '0;
    strobe.wide = longMode;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (wrEn && (wrIdx == IDX_W'(i))) strobe.load[i] = 1'b1;
    end
    strobe.topFromStatus = strobe.load[IDX_STATUS];
  end
endmodule

// File: rtl/fpcr_datapath.sv
module fpcr_datapath
  import fpcr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpcrStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] TOP_FIELD =
    DATA_W'((1 << TOP_W) - 1) << TOP_LO;

  logic [DATA_W-1:0] regFlat [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam int NB = fieldBits(g, 1'b0, DATA_W);
    localparam int WB = fieldBits(g, 1'b1, DATA_W);
    localparam logic [DATA_W-1:0] CLR = (g == IDX_STATUS) ? TOP_FIELD : '0;
    localparam logic [DATA_W-1:0] NMASK = (ALL_ONES >> (DATA_W - NB)) & ~CLR;
    localparam logic [DATA_W-1:0] WMASK = (ALL_ONES >> (DATA_W - WB)) & ~CLR;
    localparam bit IS_TOP = (g == IDX_TOP);

    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nextVal;
    logic              loadNow;

    always_comb begin
      nextVal = wrData & (strobe.wide ? WMASK : NMASK);
      loadNow = strobe.load[g];
      if (IS_TOP && strobe.topFromStatus) begin
        nextVal = DATA_W'(wrData[TOP_LO +: TOP_W]);
        loadNow = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        q <= '0;
      else if (loadNow) q <= nextVal;
    end

    assign regFlat[g] = q;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rdIdx == IDX_W'(i)) rdData = regFlat[i];
    end
    if (rdIdx == IDX_W'(IDX_STATUS))
      rdData = rdData | (DATA_W'(regFlat[IDX_TOP][TOP_W-1:0]) << TOP_LO);
  end
endmodule

// File: rtl/fpcr_bank.sv
module fpcr_bank
  import fpcr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              longMode,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  fpcrStrobe_t strobe;

  fpcr_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .longMode (longMode),
    .strobe   (strobe)
  );

  fpcr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );
endmodule

// File: rtl/fpcr_chk.sv
module fpcr_chk
  import fpcr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic              longMode,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [DATA_W-1:0] rdData
);
  // R2
  status_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == IDX_W'(IDX_STATUS)) |-> (rdData[DATA_W-1:WORD_BITS] == '0));

  // R4
  top_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == IDX_W'(IDX_TOP)) |-> (rdData[DATA_W-1:TOP_W] == '0));

  // R5
  tag_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == IDX_W'(IDX_TAG)) |-> (rdData[DATA_W-1:TAG_BITS] == '0));

  // R6
  word_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdIdx == IDX_W'(IDX_CTRL)) || (rdIdx == IDX_W'(IDX_OPC)))
      |-> (rdData[DATA_W-1:WORD_BITS] == '0));

  // R7
  simd_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == IDX_W'(IDX_SIMD)) |-> (rdData[DATA_W-1:SIMD_BITS] == '0));

  // R3
  top_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrIdx == IDX_W'(IDX_STATUS)))
      |=> ((rdIdx != IDX_W'(IDX_TOP)) ||
           (rdData == DATA_W'($past(wrData[TOP_LO +: TOP_W])))));

  // R8
  narrow_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !longMode && (wrIdx == IDX_W'(IDX_ISEL)))
      |=> ((rdIdx != IDX_W'(IDX_ISEL)) ||
           (rdData == DATA_W'($past(wrData[SEL_BITS-1:0])))));

  // R9
  wide_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && longMode && (wrIdx == IDX_W'(IDX_IOFF)))
      |=> ((rdIdx != IDX_W'(IDX_IOFF)) || (rdData == $past(wrData))));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx >= IDX_W'(NUM_REGS)) |-> (rdData == '0));
endmodule

bind fpcr_bank fpcr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrIdx    (wrIdx),
  .wrData   (wrData),
  .longMode (longMode),
  .rdIdx    (rdIdx),
  .rdData   (rdData)
);

// File: tb/sim_fpcr_bank.sv
`timescale 1ns/1ps
module sim_fpcr_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic        longMode = 1'b0;
  logic [3:0]  rdIdx = '0;
  logic [63:0] rdData;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fpcr_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .longMode(longMode), .rdIdx(rdIdx), .rdData(rdData)
  );

  // {index, longMode, write data, expected read of same index}
  localparam int NV = 13;
  localparam logic [132:0] VEC [NV] = '{
    {4'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFA5, 64'h0000_0000_0000_00A5}, // R5
    {4'd3, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_DEF0}, // R6
    {4'd4, 1'b1, 64'hFFFF_0000_0000_07FF, 64'h0000_0000_0000_07FF}, // R6
    {4'd5, 1'b0, 64'hDEAD_BEEF_0000_1F80, 64'h0000_0000_0000_1F80}, // R7
    {4'd6, 1'b0, 64'h1111_2222_3333_4444, 64'h0000_0000_0000_4444}, // R8
    {4'd6, 1'b1, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444}, // R8
    {4'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_FFFF}, // R8
    {4'd8, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0000_0000_CCCC_DDDD}, // R9
    {4'd8, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 64'hAAAA_BBBB_CCCC_DDDD}, // R9
    {4'd9, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF}, // R9
    {4'd9, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_89AB_CDEF}, // R9
    {4'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0000_0000_0005}, // R4
    {4'd0, 1'b0, 64'hFFFF_FFFF_FFFF_3A5C, 64'h0000_0000_0000_3A5C}  // R2
  };

  function automatic string reqOf(logic [3:0] idx);
    case (idx)
      4'd0: return "R2";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [3:0] idx, logic [63:0] data, logic mode);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = data; longMode = mode;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readChk(string req, logic [3:0] idx, logic [63:0] exp);
    rdIdx = idx;
    #1;
    check(req, rdData, exp);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] snap [10];
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 16; i++) readChk("R1", 4'(i), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) readChk("R1", 4'(i), 64'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      doWrite(VEC[v][132:129], VEC[v][127:64], VEC[v][128]);
      readChk(reqOf(VEC[v][132:129]), VEC[v][132:129], VEC[v][63:0]);
    end
    // R3: status write 0x3A5C loaded top with 7
    readChk("R3", 4'd1, 64'h7);
    // R8: mode drop keeps wide selector
    longMode = 1'b0;
    readChk("R8", 4'd6, 64'h1111_2222_3333_4444);

    // R3: status 0x4321 has field 0 in bits 13:11
    doWrite(4'd0, 64'h0000_0000_0000_4321, 1'b0);
    readChk("R3", 4'd1, 64'h0);
    readChk("R2", 4'd0, 64'h4321);
    // R4: top write spliced into status read
    doWrite(4'd1, 64'h3, 1'b0);
    readChk("R4", 4'd0, 64'h5B21);
    // R3: status write with field 1
    doWrite(4'd0, 64'h0000_0000_0000_0800, 1'b0);
    readChk("R3", 4'd1, 64'h1);
    readChk("R2", 4'd0, 64'h0800);

    // R10: disabled and unmapped writes change nothing
    for (int i = 0; i < 10; i++) begin rdIdx = 4'(i); #1; snap[i] = rdData; end
    @(negedge clk);
    wrEn = 1'b0; wrIdx = 4'd3; wrData = '1;
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'd12; wrData = '1; longMode = 1'b1;
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'd15; wrData = '1;
    @(negedge clk);
    wrEn = 1'b0; longMode = 1'b0;
    for (int i = 0; i < 10; i++) readChk("R10", 4'(i), snap[i]);
    readChk("R10", 4'd12, 64'h0);
    readChk("R10", 4'd15, 64'h0);

    // R11: old value until the write edge
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'd2; wrData = 64'h11;
    readChk("R11", 4'd2, 64'hA5);
    @(negedge clk);
    wrEn = 1'b0;
    readChk("R11", 4'd2, 64'h11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule